// File: doc/BRIEF.md
# Indirect Write Sequencing Register

This block is the control and status word that lets software run indirect write transfers on a serial flash controller. Software talks to it over a plain single-word register bus. A write can do three things: ask for a new transfer, abort everything outstanding, or acknowledge a finished transfer. A read returns whether the transfer engine is busy, whether the holding slots are full, a sticky completion flag and a small count of unacknowledged completions. The start address and the byte count are programmed in other registers before a transfer is requested.

On the engine side the block hands out work through a one-cycle request. It waits for the engine's one-cycle done pulse, and it can kill the running transfer with a one-cycle abort. The block holds at most two operations, the running one included. It issues the next one as soon as the engine is idle.

The register sits at byte offset 0x70 of the controller's map. The field positions below are those that software decodes.

Top module: `iwr_ctrl`

## Requirements
- R1: After reset the word reads 0. Bit 3 and bits 31:8 always read 0. The command bits 0 (start) and 1 (cancel) always read back as 0.
- R2: A write or read only acts when the address equals 0x70. A read at another address returns 0. A write at another address, or a write at 0x70 whose bits 0, 1 and 5 are all 0, changes nothing.
- R3: A write with bit 0 set queues one operation. `eng_req` is high for exactly one cycle when the engine is idle and an operation is waiting. From an idle, empty block it goes high in the second cycle after the write.
- R4: Bit 2 (busy) reads 1 from the cycle in which `eng_req` is high until the engine's done pulse has been taken.
- R5: Bit 4 (queued) reads 1 exactly when two operations are held. A start written while two are held, with no completion in that cycle, is ignored.
- R6: A done pulse while busy sets bit 5 (done flag), raises the count in bits 7:6 by one and frees a slot. A waiting operation is then requested.
- R7: The completion count in bits 7:6 saturates at 3.
- R8: A write with bit 5 set clears the done flag and lowers the count by one. The count does not go below 0.
- R9: When a completion and a write of 1 to bit 5 fall in the same cycle, the count stays unchanged and the done flag reads 1.
- R10: A write with bit 1 set pulses `eng_abort` for one cycle in the next cycle. It empties both slots, so busy and queued read 0. A done pulse in that same cycle is not counted, and a start bit in the same write is ignored. The flag and count are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| eng_req | output | 1 | One-cycle request to start a transfer |
| eng_abort | output | 1 | One-cycle abort of all transfers |
| eng_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
The hardest situations to reach are the ones where a bus write lands in exactly the cycle in which the engine reports completion. This covers both the acknowledge-versus-completion tie and the cancel-versus-completion tie. Random traffic hits them only by chance. The bench engine model therefore has a settable latency. Set to one cycle, it places its done pulse on the clock edge right after the request is seen, and the bench drives the clashing write on that same edge. Random phases with frequent starts, acknowledges and rare cancels then sweep the saturation and full-queue corners against a cycle-level reference model.

// File: rtl/iwr_pkg.sv
package iwr_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned BIT_START  = 0;
  localparam int unsigned BIT_CANCEL = 1;
  localparam int unsigned BIT_BUSY   = 2;
  localparam int unsigned BIT_FULL   = 4;
  localparam int unsigned BIT_FLAG   = 5;
  localparam int unsigned CNT_LSB    = 6;
  localparam int unsigned CNT_W      = 2;
  localparam int unsigned CNT_MAX    = (1 << CNT_W) - 1;

  typedef struct packed {
    logic start;
    logic cancel;
    logic clear;
  } iwr_cmd_t;

  typedef struct packed {
    logic             busy;
    logic             full;
    logic             flag;
    logic [CNT_W-1:0] cnt;
  } iwr_stat_t;

  // Occupancy after one cycle: a completion frees a slot first, then a
  // start takes one if the limit allows.
  function automatic int unsigned held_next(int unsigned held, logic fin,
                                            logic start, int unsigned depth);
    int unsigned h;
    h = (fin && held != 0) ? held - 1 : held;
    if (start && h < depth) h = h + 1;
    return h;
  endfunction

  // Completion counter: increment on completion, decrement on acknowledge,
  // both at once leave it alone; clamps at both ends.
  function automatic logic [CNT_W-1:0] cnt_next(logic [CNT_W-1:0] cur,
                                                logic fin, logic clr);
    logic [CNT_W-1:0] n;
    n = cur;
    if (fin && !clr && cur != CNT_W'(CNT_MAX)) n = cur + 1'b1;
    else if (clr && !fin && cur != '0)         n = cur - 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/iwr_bus_if.sv
module iwr_bus_if
  import iwr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h70)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  iwr_stat_t         stat,
  output iwr_cmd_t          cmd,
  output logic [REG_W-1:0]  rdata
);

  logic hit;
  logic wr_hit;
  logic rd_hit;
  logic [REG_W-1:0] word;
  logic unused_wbits;

  assign hit    = (addr == REG_OFFSET);
  assign wr_hit = wr && hit;
  assign rd_hit = rd && hit;

  assign cmd.start  = wr_hit && wdata[BIT_START];
  assign cmd.cancel = wr_hit && wdata[BIT_CANCEL];
  assign cmd.clear  = wr_hit && wdata[BIT_FLAG];

  assign unused_wbits = ^{wdata[REG_W-1:BIT_FLAG+1], wdata[BIT_FLAG-1:BIT_CANCEL+1]};

  always_comb begin
    word                          = '0;
    word[BIT_BUSY]                = stat.busy;
    word[BIT_FULL]                = stat.full;
    word[BIT_FLAG]                = stat.flag;
    word[CNT_LSB +: CNT_W]        = stat.cnt;
  end

  assign rdata = rd_hit ? word : '0;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[REG_W-1:CNT_LSB+CNT_W] == '0) && !rdata[3] && (rdata[1:0] == 2'b00)); // R1
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == '0); // R2

endmodule

// File: rtl/iwr_queue.sv
module iwr_queue
  import iwr_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  input  logic eng_done,
  output logic eng_req,
  output logic eng_abort,
  output logic busy,
  output logic full,
  output logic finish_evt
);

  localparam int unsigned HW = $clog2(DEPTH + 1);

  logic [HW-1:0] held_q;
  logic [HW-1:0] held_d;
  logic          active_q;
  logic          req_q;
  logic          abort_q;
  logic          issue;
  logic          start_ok;

  // Completion only counts while a transfer runs and no cancel wins.
  assign finish_evt = eng_done && active_q && !cancel;
  assign issue      = !active_q && (held_q != '0) && !cancel;
  assign held_d     = HW'(held_next(int'(held_q), finish_evt, start, DEPTH));
  assign start_ok   = start && !cancel && (held_d != held_q || finish_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      active_q <= 1'b0;
      req_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= cancel;
      req_q   <= issue;
      if (cancel) begin
        held_q   <= '0;
        active_q <= 1'b0;
      end else begin
        held_q   <= held_d;
        active_q <= issue || (active_q && !finish_evt);
      end
    end
  end

  assign eng_req   = req_q;
  assign eng_abort = abort_q;
  assign busy      = active_q;
  assign full      = (held_q == HW'(DEPTH));

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R3
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> req_q); // R4
  AST_HELD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    held_q <= HW'(DEPTH)); // R5
  AST_FULL_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (full && start && !cancel && !eng_done) |=> held_q == $past(held_q)); // R5
  AST_CANCEL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (held_q == '0) && !active_q && eng_abort); // R10
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_abort && !cancel) |=> !eng_abort); // R10
  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !finish_evt) |=> held_q == $past(held_q) + 1'b1); // R3

endmodule

// File: rtl/iwr_status.sv
module iwr_status
  import iwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish_evt,
  input  logic             clear,
  output logic             flag,
  output logic [CNT_W-1:0] cnt
);

  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_next(cnt_q, finish_evt, clear);
      if (finish_evt)  flag_q <= 1'b1;
      else if (clear)  flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
  assign cnt  = cnt_q;

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> flag_q); // R6
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(CNT_MAX) && finish_evt && !clear) |=> cnt_q == CNT_W'(CNT_MAX)); // R7
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && clear && !finish_evt) |=> (cnt_q == '0) && !flag_q); // R8
  AST_TIE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && clear) |=> flag_q && (cnt_q == $past(cnt_q))); // R9

endmodule

// File: rtl/iwr_ctrl.sv
module iwr_ctrl
  import iwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h70),
  parameter int unsigned DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_req,
  output logic              eng_abort,
  input  logic              eng_done
);

  iwr_cmd_t  cmd;
  iwr_stat_t stat;
  logic      finish_evt;

  iwr_bus_if #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .stat  (stat),
    .cmd   (cmd),
    .rdata (bus_rdata)
  );

  iwr_queue #(.DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cmd.start),
    .cancel     (cmd.cancel),
    .eng_done   (eng_done),
    .eng_req    (eng_req),
    .eng_abort  (eng_abort),
    .busy       (stat.busy),
    .full       (stat.full),
    .finish_evt (finish_evt)
  );

  iwr_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .finish_evt (finish_evt),
    .clear      (cmd.clear),
    .flag       (stat.flag),
    .cnt        (stat.cnt)
  );

  AST_NO_COUNT_ON_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.cancel |=> stat.cnt == $past(stat.cnt) || $past(cmd.clear)); // R10

endmodule

// File: tb/iwr_ctrl_tb.sv
`timescale 1ns/1ps
module iwr_ctrl_tb;

  localparam logic [7:0] OFF = 8'h70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_req;
  logic        eng_abort;
  logic        eng_done = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int eng_lat = 0;
  int eng_rem = 0;
  bit finished = 0;

  // reference model state
  int m_held = 0;
  bit m_active = 0;
  bit m_req = 0;
  bit m_abort = 0;
  bit m_flag = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  iwr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_req(eng_req), .eng_abort(eng_abort), .eng_done(eng_done)
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = '0;
    w[2] = m_active;
    w[4] = (m_held == 2);
    w[5] = m_flag;
    w[7:6] = m_cnt[1:0];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // cycle-level reference, from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_held = 0; m_active = 0; m_req = 0; m_abort = 0; m_flag = 0; m_cnt = 0;
    end else begin
      bit w, st, cn, cl, dn, iss;
      int h;
      w  = bus_wr && bus_addr == OFF;
      st = w && bus_wdata[0];
      cn = w && bus_wdata[1];
      cl = w && bus_wdata[5];
      dn = eng_done && m_active && !cn;
      iss = !m_active && m_held > 0 && !cn;
      m_abort = cn;
      m_req = iss;
      if (cn) begin
        m_held = 0; m_active = 0;
      end else begin
        h = dn ? m_held - 1 : m_held;
        if (st && h < 2) h++;
        m_held = h;
        m_active = iss || (m_active && !dn);
      end
      if (dn && cl) m_flag = 1;
      else if (dn) begin m_flag = 1; if (m_cnt < 3) m_cnt++; end
      else if (cl) begin m_flag = 0; if (m_cnt > 0) m_cnt--; end
    end
  end

  // transfer engine model and per-cycle handshake checks
  always @(negedge clk) begin
    eng_done <= 1'b0;
    if (rst_n) begin
      chk("R3 eng_req", {31'b0, eng_req}, {31'b0, m_req});
      chk("R10 eng_abort", {31'b0, eng_abort}, {31'b0, m_abort});
      if (eng_abort) eng_rem = 0;
      else if (eng_req) eng_rem = (eng_lat != 0) ? eng_lat : 1 + int'($urandom % 6);
      else if (eng_rem > 0) begin
        eng_rem--;
        if (eng_rem == 0) eng_done <= 1'b1;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  // read at the register, compare field by field with the model
  task automatic rd_model();
    logic [31:0] e;
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_addr = OFF;
    #1;
    e = exp_word();
    chk("R1 reserved", bus_rdata & 32'hFFFF_FF0B, 32'h0);
    chk("R4 busy", {31'b0, bus_rdata[2]}, {31'b0, e[2]});
    chk("R5 queued", {31'b0, bus_rdata[4]}, {31'b0, e[4]});
    chk("R6 flag", {31'b0, bus_rdata[5]}, {31'b0, e[5]});
    chk("R7 count", {30'b0, bus_rdata[7:6]}, {30'b0, e[7:6]});
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) idle();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd_expect("R1 reset value", OFF, 32'h0);

    // R2: foreign address and zero writes do nothing
    wr(8'h74, 32'h1);
    wr(OFF, 32'h0);
    settle(3);
    rd_expect("R2 no effect", OFF, 32'h0);

    // R3 request timing from idle: write, then req in the second cycle
    eng_lat = 20;
    wr(OFF, 32'h1);
    idle();
    #1 chk("R3 no req first cycle", {31'b0, eng_req}, 32'h0);
    idle();
    #1 chk("R3 req second cycle", {31'b0, eng_req}, 32'h1);
    // R5: fill to two, third start ignored
    wr(OFF, 32'h1);
    wr(OFF, 32'h1);
    rd_expect("R5 full busy", OFF, 32'h14);
    rd_expect("R2 other addr reads 0", 8'h6C, 32'h0);
    settle(22);
    rd_expect("R6 one done, next running", OFF, 32'h64);
    // R10 cancel clears slots, keeps flag and count
    wr(OFF, 32'h1 | 32'h2);
    settle(2);
    rd_expect("R10 after cancel", OFF, 32'h60);
    settle(25);
    rd_expect("R10 nothing revived", OFF, 32'h60);

    // R7 saturation
    eng_lat = 1;
    for (int i = 0; i < 4; i++) begin wr(OFF, 32'h1); settle(5); end
    rd_expect("R7 saturated", OFF, 32'hE0);
    // R8 clear and floor
    wr(OFF, 32'h20);
    rd_expect("R8 one acknowledged", OFF, 32'h80);
    for (int i = 0; i < 3; i++) wr(OFF, 32'h20);
    rd_expect("R8 floor at zero", OFF, 32'h0);

    // R9 acknowledge on the completion edge
    wr(OFF, 32'h1); settle(5);
    wr(OFF, 32'h1);
    do idle(); while (!eng_req);
    wr(OFF, 32'h20);
    idle();
    rd_expect("R9 tie keeps count", OFF, 32'h60);

    // R10 cancel on the completion edge
    wr(OFF, 32'h1);
    do idle(); while (!eng_req);
    wr(OFF, 32'h2);
    settle(2);
    rd_expect("R10 cancel beats done", OFF, 32'h60);

    // random phase against the model
    eng_lat = 0;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 35) rd_model();
      else if (r < 75) begin
        logic [31:0] d;
        d = $urandom;
        d[1] = ($urandom % 30) == 0;
        wr((($urandom % 8) == 0) ? 8'h74 : OFF, d);
      end else idle();
    end
    settle(10);
    rd_model();
    finish_run();
  end

endmodule